// File: doc/BRIEF.md
# Four-Way Junction Signal Sequencer

This block sequences the vehicle lamps and the pedestrian indications at a crossing of four roads that share equal priority. In day operation each road receives a green interval in a fixed round-robin order: road 0 (north), road 1 (east), road 2 (south), road 3 (west), and then back to road 0. A green road may turn left, go straight or turn right, so all three other roads show red at that time.

Every change of right-of-way passes through two yellow sub-steps. First the road that is losing green shows yellow. Then the road about to gain green shows yellow together with its pedestrian indication. After that the direction index advances and the incoming road turns green. Each road's green length is its own parameter, counted in ticks. A separate divider outside the block supplies the ticks. A night input replaces the rotation with all four yellow lamps flashing in unison. When night ends, the sequence restarts from its reset state.

Top module: `junction_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, road 0 shows green and roads 1 to 3 show red. No yellow lamp and no pedestrian output is on. Bit k of each 4-bit output belongs to road k.
- R2: Road k stays green for exactly GREEN_TICKS[k] ticks. Counting starts from the tick that turned it green.
- R3: When a green interval ends, the outgoing road shows yellow for YEL_TICKS ticks. The other three roads show red.
- R4: Next, the incoming road (outgoing index + 1, modulo 4) shows yellow with its pedestrian output on, for YEL_TICKS ticks. Every other road, including the outgoing road, shows red.
- R5: After the second yellow sub-step the incoming road turns green. Service follows the order 0, 1, 2, 3 and then wraps to 0.
- R6: Outside night mode each road shows exactly one of red, yellow or green, at most one road is green, and a pedestrian output is on only while its road shows yellow.
- R7: A clock edge with the tick input low and the night input low leaves all outputs unchanged.
- R8: While the night input is high, every red, green and pedestrian output is off. In the first cycle of night mode all yellows are off, and a tick in that entry cycle is ignored. After that, every tick toggles all four yellows together.
- R9: When the night input falls, the block returns to the R1 state with a fresh road-0 green count.
- R10: Reset overrides the night input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| night_i | input | 1 | High selects flashing night operation |
| tick_i | input | 1 | One-cycle timing pulse from the external divider |
| red_o | output | 4 | Red lamp per road |
| yel_o | output | 4 | Yellow lamp per road |
| grn_o | output | 4 | Green lamp per road |
| walk_o | output | 4 | Pedestrian indication per road |

## Verification
The bound checker enforces the safety rules on every cycle. These are one lamp per road in day mode, never two greens, pedestrian output only with yellow, and the dark or uniform yellow pattern in night mode. It also checks that a green road can leave green only through its own yellow, and that a cycle without a tick changes no output. Only the scoreboard scenarios can show timing and order: the per-road green lengths, the yellow durations, the wrap from road 3 to road 0, the flash phase, and the fresh restart after night or reset.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
    localparam int ROADS = 4;
    localparam int DIR_W = 2;

    typedef enum logic [1:0] {
        STEP_GREEN = 2'd0,
        STEP_OUT   = 2'd1,
        STEP_IN    = 2'd2
    } step_e;

    typedef enum logic {
        MODE_DAY   = 1'b0,
        MODE_NIGHT = 1'b1
    } mode_e;

    typedef struct packed {
        logic [ROADS-1:0] red;
        logic [ROADS-1:0] yel;
        logic [ROADS-1:0] grn;
        logic [ROADS-1:0] walk;
    } lamps_t;
endpackage

// File: rtl/jseq_dwell.sv
module jseq_dwell
    import jseq_pkg::*;
#(
    parameter int CNT_W                = 8,
    parameter int GREEN_TICKS [ROADS]  = '{4, 2, 3, 2},
    parameter int YEL_TICKS            = 2
) (
    input  step_e             step_i,
    input  logic [DIR_W-1:0]  dir_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              last_o
);
    localparam logic [CNT_W-1:0] YEL_M1 = CNT_W'(YEL_TICKS - 1);

    logic [CNT_W-1:0] green_m1 [ROADS];
    logic [CNT_W-1:0] limit;

    for (genvar g = 0; g < ROADS; g++) begin : g_len
        assign green_m1[g] = CNT_W'(GREEN_TICKS[g] - 1);
    end

    always_comb begin
        if (step_i == STEP_GREEN) limit = green_m1[dir_i];
        else                      limit = YEL_M1;
    end

    assign last_o = (cnt_i == limit);
endmodule

// File: rtl/jseq_lamp_decode.sv
module jseq_lamp_decode
    import jseq_pkg::*;
(
    input  mode_e             mode_i,
    input  step_e             step_i,
    input  logic [DIR_W-1:0]  dir_i,
    input  logic              flash_i,
    output lamps_t            lamps_o
);
    logic [DIR_W-1:0] dir_nxt;
    assign dir_nxt = dir_i + DIR_W'(1);

    for (genvar k = 0; k < ROADS; k++) begin : g_road
        localparam logic [DIR_W-1:0] K = DIR_W'(k);
        always_comb begin
            lamps_o.red[k]  = 1'b0;
            lamps_o.yel[k]  = 1'b0;
            lamps_o.grn[k]  = 1'b0;
            lamps_o.walk[k] = 1'b0;
            if (mode_i == MODE_NIGHT) begin
                lamps_o.yel[k] = flash_i;
            end else begin
                case (step_i)
                    STEP_GREEN: begin
                        lamps_o.grn[k] = (dir_i == K);
                        lamps_o.red[k] = (dir_i != K);
                    end
                    STEP_OUT: begin
                        lamps_o.yel[k] = (dir_i == K);
                        lamps_o.red[k] = (dir_i != K);
                    end
                    STEP_IN: begin
                        lamps_o.yel[k]  = (dir_nxt == K);
                        lamps_o.walk[k] = (dir_nxt == K);
                        lamps_o.red[k]  = (dir_nxt != K);
                    end
                    default: lamps_o.red[k] = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/junction_sequencer.sv
module junction_sequencer
    import jseq_pkg::*;
#(
    parameter int CNT_W               = 8,
    parameter int GREEN_TICKS [ROADS] = '{4, 2, 3, 2},
    parameter int YEL_TICKS           = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             night_i,
    input  logic             tick_i,
    output logic [ROADS-1:0] red_o,
    output logic [ROADS-1:0] yel_o,
    output logic [ROADS-1:0] grn_o,
    output logic [ROADS-1:0] walk_o
);
    typedef struct packed {
        mode_e            mode;
        step_e            step;
        logic [DIR_W-1:0] dir;
        logic [CNT_W-1:0] cnt;
        logic             flash;
    } st_t;

    localparam st_t ST_S0 = '{
        mode:  MODE_DAY,
        step:  STEP_GREEN,
        dir:   '0,
        cnt:   '0,
        flash: 1'b0
    };

    st_t    st_d, st_q;
    logic   last;
    lamps_t lamps;

    jseq_dwell #(
        .CNT_W       (CNT_W),
        .GREEN_TICKS (GREEN_TICKS),
        .YEL_TICKS   (YEL_TICKS)
    ) u_dwell (
        .step_i (st_q.step),
        .dir_i  (st_q.dir),
        .cnt_i  (st_q.cnt),
        .last_o (last)
    );

    always_comb begin
        st_d = st_q;
        if (night_i) begin
            if (st_q.mode == MODE_DAY) begin
                st_d.mode  = MODE_NIGHT;
                st_d.flash = 1'b0;
            end else if (tick_i) begin
                st_d.flash = ~st_q.flash;
            end
        end else if (st_q.mode == MODE_NIGHT) begin
            st_d = ST_S0;
        end else if (tick_i) begin
            if (last) begin
                st_d.cnt = '0;
                case (st_q.step)
                    STEP_GREEN: st_d.step = STEP_OUT;
                    STEP_OUT:   st_d.step = STEP_IN;
                    default: begin
                        st_d.step = STEP_GREEN;
                        st_d.dir  = st_q.dir + DIR_W'(1);
                    end
                endcase
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_S0;
        else       st_q <= st_d;
    end

    jseq_lamp_decode u_decode (
        .mode_i  (st_q.mode),
        .step_i  (st_q.step),
        .dir_i   (st_q.dir),
        .flash_i (st_q.flash),
        .lamps_o (lamps)
    );

    assign red_o  = lamps.red;
    assign yel_o  = lamps.yel;
    assign grn_o  = lamps.grn;
    assign walk_o = lamps.walk;
endmodule

// File: rtl/jseq_checker.sv
module jseq_checker #(
    parameter int ROADS_N = 4
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               night_i,
    input logic               tick_i,
    input logic [ROADS_N-1:0] red_i,
    input logic [ROADS_N-1:0] yel_i,
    input logic [ROADS_N-1:0] grn_i,
    input logic [ROADS_N-1:0] walk_i
);
    // R6
    single_green_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(grn_i));

    // R6
    day_three_red_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (red_i != '0) |-> ($countones(red_i) == ROADS_N - 1));

    // R8
    night_dark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (red_i == '0) |-> (grn_i == '0 && walk_i == '0 &&
                           (yel_i == '0 || yel_i == '1)));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !night_i && red_i != '0) |=>
            $stable({red_i, yel_i, grn_i, walk_i}));

    for (genvar k = 0; k < ROADS_N; k++) begin : g_road
        // R6
        one_lamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (red_i != '0) |-> ($countones({red_i[k], yel_i[k], grn_i[k]}) == 1));

        // R6
        walk_yellow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            walk_i[k] |-> yel_i[k]);

        // R3
        green_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (grn_i[k] && !night_i) |=> (grn_i[k] || yel_i[k]));
    end
endmodule

bind junction_sequencer jseq_checker #(.ROADS_N(4)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .night_i (night_i),
    .tick_i  (tick_i),
    .red_i   (red_o),
    .yel_i   (yel_o),
    .grn_i   (grn_o),
    .walk_i  (walk_o)
);

// File: tb/tb_junction_sequencer.sv
`timescale 1ns/1ps
module tb_junction_sequencer;
    localparam int GT [4] = '{3, 5, 2, 4};
    localparam int YT     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic night = 1'b0;
    logic tick = 1'b0;
    logic [3:0] red, yel, grn, walk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] r, y, g, w;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    junction_sequencer #(
        .CNT_W(8), .GREEN_TICKS(GT), .YEL_TICKS(YT)
    ) dut (
        .clk_i(clk), .rst_i(rst), .night_i(night), .tick_i(tick),
        .red_o(red), .yel_o(yel), .grn_o(grn), .walk_o(walk)
    );

    function automatic exp_t mk_green(int k, string tag);
        exp_t e;
        e.g = 4'(1 << k); e.r = ~e.g; e.y = '0; e.w = '0; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t mk_out(int k, string tag);
        exp_t e;
        e.y = 4'(1 << k); e.r = ~e.y; e.g = '0; e.w = '0; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t mk_in(int k, string tag);
        exp_t e;
        e.y = 4'(1 << ((k + 1) % 4)); e.r = ~e.y; e.g = '0; e.w = e.y; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t mk_night(bit lit, string tag);
        exp_t e;
        e.y = lit ? 4'hF : 4'h0; e.r = '0; e.g = '0; e.w = '0; e.tag = tag;
        return e;
    endfunction

    // Driver: inputs change at the falling edge; the item is due after the next rising edge.
    task automatic drive(bit r_in, bit n_in, bit t_in, exp_t e);
        @(negedge clk);
        rst = r_in; night = n_in; tick = t_in;
        q.push_back(e);
    endtask

    task automatic rotation(bit first);
        for (int k = 0; k < 4; k++) begin
            int n;
            n = (k == 0 && first) ? GT[0] - 1 : GT[k];
            for (int i = 0; i < n; i++) drive(0, 0, 1, mk_green(k, "R2/R5 green"));
            for (int i = 0; i < YT; i++) drive(0, 0, 1, mk_out(k, "R3 outgoing yellow"));
            for (int i = 0; i < YT; i++) drive(0, 0, 1, mk_in(k, "R4 incoming yellow+walk"));
        end
    endtask

    // Monitor: compares one item per cycle, away from the active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({red, yel, grn, walk} !== {e.r, e.y, e.g, e.w}) begin
                    fails++;
                    $display("FAIL %s: got r=%b y=%b g=%b w=%b expected r=%b y=%b g=%b w=%b",
                             e.tag, red, yel, grn, walk, e.r, e.y, e.g, e.w);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #200us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): got hung run, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(1, 0, 0, mk_green(0, "R1 reset"));
        drive(0, 0, 0, mk_green(0, "R1 after reset"));
        // R2 R3 R4 R5: two full rotations, including the wrap from road 3 to road 0
        rotation(1'b1);
        rotation(1'b0);
        // R7: no tick, no change
        for (int i = 0; i < 3; i++) drive(0, 0, 0, mk_in(3, "R7 hold"));
        for (int i = 0; i < GT[0]; i++) begin
            drive(0, 0, 1, mk_green(0, "R2 green with gaps"));
            drive(0, 0, 0, mk_green(0, "R7 hold in green"));
        end
        drive(0, 0, 1, mk_out(0, "R3 after gapped green"));
        // R8: night entry ignores a same-cycle tick, then toggles on each tick
        drive(0, 1, 1, mk_night(0, "R8 entry dark"));
        drive(0, 1, 0, mk_night(0, "R8 no tick"));
        drive(0, 1, 1, mk_night(1, "R8 flash on"));
        drive(0, 1, 1, mk_night(0, "R8 flash off"));
        drive(0, 1, 1, mk_night(1, "R8 flash on again"));
        drive(0, 1, 0, mk_night(1, "R8 hold lit"));
        // R9: leaving night restarts with a fresh road-0 green
        drive(0, 0, 0, mk_green(0, "R9 restart"));
        for (int i = 0; i < GT[0] - 1; i++) drive(0, 0, 1, mk_green(0, "R9 fresh count"));
        drive(0, 0, 1, mk_out(0, "R9 green ends on time"));
        drive(0, 0, 1, mk_out(0, "R3 yellow held"));
        // R10: reset wins over night
        drive(1, 1, 1, mk_green(0, "R10 reset over night"));
        drive(1, 1, 0, mk_green(0, "R10 reset over night"));
        drive(0, 1, 0, mk_night(0, "R8 entry after reset"));
        drive(0, 0, 1, mk_green(0, "R9 restart after night"));
        @(negedge clk);
        tick = 0;
        @(posedge clk);
        #2;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule